// File: doc/BRIEF.md
# Feed-Forward Duty Combiner with Complementary PWM

This block produces the gate drive for the two fast switches of a bridgeless boost rectifier leg. The drive is updated once per control sample. When a sample strobe arrives, the block takes the magnitude of the sensed grid voltage and the sensed bus voltage and computes their ratio with a sequential divider. It forms a feed-forward duty from that ratio, and the formula depends on which grid polarity is flagged. It then adds the signed duty correction from the current controller and saturates the sum to the range zero to one.

The saturated duty is scaled to a compare threshold on a free-running carrier. The threshold is loaded only when the carrier wraps. The main gate is on while the carrier is below the threshold, and the complementary gate is on for the rest of the period. A fixed dead-time is carved out of each on-interval after every transition. If no valid polarity is flagged, or if the force-off input is high, both gates are held low.

Duty values use F fractional bits, so 2^F stands for a duty of 1.0. The correction input is two's complement on the same scale.

Top module: `ff_duty_pwm`

## Requirements
- R1: While reset is high and afterwards with no polarity flagged, both gate outputs are low; the carrier restarts from zero.
- R2: With the positive flag latched at the sample, the feed-forward duty is 2^F − q, where q = min(floor(|grid_v|·2^F / bus'), 2^F) and bus' is the clamped bus voltage.
- R3: With the negative flag latched at the sample, the feed-forward duty is q itself, so a negative grid voltage yields a positive duty.
- R4: The final duty is the feed-forward duty plus the signed `pi_duty`, clamped to the range [0, 2^F].
- R5: The threshold is thr = floor(duty·PERIOD / 2^F). In steady state, each carrier period `gate_main` is high for max(thr−DEADT, 0) cycles and `gate_comp` for max(PERIOD−thr−DEADT, 0) cycles. When thr = 0, `gate_comp` is high for the whole period; when thr = PERIOD, `gate_main` is high for the whole period.
- R6: The two gates are never high together. Before either gate turns on, both have been low for at least DEADT cycles.
- R7: If neither flag or both flags are set, or if `force_off` is high, both gates go low one clock later and stay low.
- R8: A bus voltage below VDC_MIN (zero and negative values included) is replaced by VDC_MIN in the division.
- R9: A new threshold takes effect only when the carrier wraps from PERIOD−1 to 0. A sample that arrives mid-period does not alter the current period, so `gate_main` rises at most once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe that latches a new control sample |
| grid_v | input | W | Signed sensed grid voltage |
| bus_v | input | W | Signed sensed bus voltage |
| pi_duty | input | DCW | Signed current-controller duty correction, 2^F = 1.0 |
| pol_pos | input | 1 | Positive half-cycle flag |
| pol_neg | input | 1 | Negative half-cycle flag |
| force_off | input | 1 | Holds both gates low while high |
| gate_comp | output | 1 | Complementary fast switch gate |
| gate_main | output | 1 | Main fast switch gate, on for the duty fraction |

## Verification
A wrong quotient or a wrong feed-forward branch appears as a wrong high-time on `gate_main` and `gate_comp`, starting with the first full carrier period after the next wrap. A dead-time counter that is out of step appears at the next switching edge, as a gap shorter than DEADT or as both gates high. A threshold register that is loaded at the wrong moment appears within the same period as a second rising edge of `gate_main`. Disable logic that is held in a stale state appears one clock after a flag change.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_t;
  typedef enum logic {DIV_IDLE = 1'b0, DIV_RUN = 1'b1} div_state_t;
endpackage

// File: rtl/dfp_divider.sv
module dfp_divider
  import dfp_pkg::*;
#(
  parameter int NW = 28,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int STW = $clog2(NW + 1);

  div_state_t     st;
  logic [NW-1:0]  num_sh, num_hold, q_r;
  logic [DW:0]    rem;
  logic [DW-1:0]  den_r;
  logic [STW-1:0] step;
  logic [DW:0]    trial;

  always_comb trial = {rem[DW-1:0], num_sh[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= DIV_IDLE; done <= 1'b0; num_sh <= '0; num_hold <= '0;
      q_r <= '0; rem <= '0; den_r <= '0; step <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        num_sh <= num; num_hold <= num; den_r <= den;
        rem <= '0; q_r <= '0; step <= '0; st <= DIV_RUN;
      end else if (st == DIV_RUN) begin
        num_sh <= num_sh << 1;
        if (trial >= {1'b0, den_r}) begin
          rem <= trial - {1'b0, den_r};
          q_r <= {q_r[NW-2:0], 1'b1};
        end else begin
          rem <= trial;
          q_r <= {q_r[NW-2:0], 1'b0};
        end
        if (step == STW'(NW - 1)) begin
          st <= DIV_IDLE;
          done <= 1'b1;
        end
        step <= step + 1'b1;
      end
    end
  end

  assign quot = q_r;

  // Quotient is exact floor division: q*d <= n < (q+1)*d (feeds R2, R3)
  logic [NW+DW-1:0] prod_chk, num_w, den_w;
  assign prod_chk = quot * den_r;
  assign num_w    = {{DW{1'b0}}, num_hold};
  assign den_w    = {{NW{1'b0}}, den_r};
  assert_quot_exact_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (prod_chk <= num_w) && ((num_w - prod_chk) < den_w));
endmodule

// File: rtl/dfp_combine.sv
module dfp_combine
  import dfp_pkg::*;
#(
  parameter int F      = 12,
  parameter int NW     = 28,
  parameter int DCW    = 14,
  parameter int PERIOD = 10000,
  parameter int TW     = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [NW-1:0]         quot,
  input  pol_t                  pol,
  input  logic signed [DCW-1:0] corr,
  output logic [TW-1:0]         thr
);
  localparam int ONE   = 1 << F;
  localparam int BASEW = (F + 2 > DCW) ? F + 2 : DCW;
  localparam int SW    = BASEW + 1;
  localparam int PW    = F + 1 + TW;

  logic [F:0]           q_sat, duty;
  logic signed [SW-1:0] ratio_s, ff, corr_s, sum;
  logic [PW-1:0]        prod;

  always_comb begin
    q_sat   = (quot > NW'(ONE)) ? (F+1)'(ONE) : quot[F:0];
    ratio_s = $signed({{(SW-F-1){1'b0}}, q_sat});
    ff      = (pol == POL_POS) ? (SW'(ONE) - ratio_s) : ratio_s;
    corr_s  = $signed({{(SW-DCW){corr[DCW-1]}}, corr});
    sum     = ff + corr_s;
    if (sum < 0)             duty = '0;
    else if (sum > SW'(ONE)) duty = (F+1)'(ONE);
    else                     duty = sum[F:0];
    prod = PW'(duty) * PW'(PERIOD);
  end

  always_ff @(posedge clk) begin
    if (rst)       thr <= '0;
    else if (load) thr <= TW'(prod >> F);
  end
endmodule

// File: rtl/dfp_pwm.sv
module dfp_pwm #(
  parameter int PERIOD = 10000,
  parameter int DEADT  = 50,
  parameter int TW     = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] thr_in,
  input  logic          en,
  output logic          g_comp,
  output logic          g_main
);
  localparam int CW  = $clog2(PERIOD);
  localparam int DTW = $clog2(DEADT + 1);

  logic [CW-1:0]  cnt;
  logic [TW-1:0]  thr_act;
  logic [DTW-1:0] dt;
  logic           raw, raw_q, wrap, dt_full;

  always_comb begin
    wrap    = (cnt == CW'(PERIOD - 1));
    raw     = (TW'(cnt) < thr_act);
    dt_full = (dt == DTW'(DEADT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; thr_act <= '0; raw_q <= 1'b0; dt <= '0;
      g_comp <= 1'b0; g_main <= 1'b0;
    end else begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      if (wrap) thr_act <= thr_in;
      raw_q <= raw;
      if (!en || (raw != raw_q)) dt <= '0;
      else if (!dt_full)         dt <= dt + 1'b1;
      g_main <= en && raw_q && dt_full;
      g_comp <= en && !raw_q && dt_full;
    end
  end

  // checker state: consecutive cycles with both gates low
  logic [DTW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)                  gap <= '0;
    else if (g_comp | g_main) gap <= '0;
    else if (gap != DTW'(DEADT)) gap <= gap + 1'b1;
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(g_comp && g_main));
  assert_main_deadtime_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(g_main) |-> (gap >= DTW'(DEADT)));
  assert_comp_deadtime_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(g_comp) |-> (gap >= DTW'(DEADT)));
  assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!g_comp && !g_main));
  assert_thr_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (thr_act != $past(thr_act)) |-> $past(wrap));
endmodule

// File: rtl/ff_duty_pwm.sv
module ff_duty_pwm
  import dfp_pkg::*;
#(
  parameter int W       = 16,
  parameter int F       = 12,
  parameter int DCW     = F + 2,
  parameter int PERIOD  = 10000,
  parameter int DEADT   = 50,
  parameter int VDC_MIN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_stb,
  input  logic signed [W-1:0]   grid_v,
  input  logic signed [W-1:0]   bus_v,
  input  logic signed [DCW-1:0] pi_duty,
  input  logic                  pol_pos,
  input  logic                  pol_neg,
  input  logic                  force_off,
  output logic                  gate_comp,
  output logic                  gate_main
);
  localparam int NW = W + F;
  localparam int TW = $clog2(PERIOD + 1);

  logic [W-1:0]          grid_mag, bus_eff;
  logic [NW-1:0]         num, quot;
  logic                  div_done, en;
  pol_t                  pol_lat;
  logic signed [DCW-1:0] corr_lat;
  logic [TW-1:0]         thr_pend;

  always_comb begin
    grid_mag = grid_v[W-1] ? (~grid_v + 1'b1) : grid_v;
    bus_eff  = ($signed(bus_v) < $signed(W'(VDC_MIN))) ? W'(VDC_MIN) : bus_v;
    num      = {grid_mag, {F{1'b0}}};
    en       = (pol_pos ^ pol_neg) & ~force_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_lat  <= POL_NEG;
      corr_lat <= '0;
    end else if (sample_stb) begin
      pol_lat  <= pol_pos ? POL_POS : POL_NEG;
      corr_lat <= pi_duty;
    end
  end

  dfp_divider #(.NW(NW), .DW(W)) u_div (
    .clk(clk), .rst(rst), .start(sample_stb), .num(num), .den(bus_eff),
    .done(div_done), .quot(quot)
  );

  dfp_combine #(.F(F), .NW(NW), .DCW(DCW), .PERIOD(PERIOD), .TW(TW)) u_comb (
    .clk(clk), .rst(rst), .load(div_done), .quot(quot), .pol(pol_lat),
    .corr(corr_lat), .thr(thr_pend)
  );

  dfp_pwm #(.PERIOD(PERIOD), .DEADT(DEADT), .TW(TW)) u_pwm (
    .clk(clk), .rst(rst), .thr_in(thr_pend), .en(en),
    .g_comp(gate_comp), .g_main(gate_main)
  );
endmodule

// File: tb/ff_duty_pwm_bench.sv
module ff_duty_pwm_bench;
  localparam int W = 16, F = 12, DCW = F + 2, P = 100, DT = 3, VMIN = 64;
  localparam int ONE = 1 << F;

  logic clk = 1'b0, rst = 1'b1, stb = 1'b0;
  logic signed [W-1:0] grid_v = '0, bus_v = '0;
  logic signed [DCW-1:0] pi_duty = '0;
  logic pol_pos = 1'b0, pol_neg = 1'b0, force_off = 1'b0;
  logic gate_comp, gate_main;

  int total = 0, bad = 0, req_cnt = 0, ack_cnt = 0;
  int overlap_err = 0, gap_err = 0, off_run = 0;
  logic prev_c = 1'b0, prev_m = 1'b0;

  typedef struct { int main_n; int comp_n; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  ff_duty_pwm #(.W(W), .F(F), .DCW(DCW), .PERIOD(P), .DEADT(DT), .VDC_MIN(VMIN))
  u_ff_duty_pwm (
    .clk(clk), .rst(rst), .sample_stb(stb), .grid_v(grid_v), .bus_v(bus_v),
    .pi_duty(pi_duty), .pol_pos(pol_pos), .pol_neg(pol_neg), .force_off(force_off),
    .gate_comp(gate_comp), .gate_main(gate_main)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_thr(input int gv, input int bv, input int corr, input bit pos);
    int mag, den, ff, d;
    longint q;
    mag = (gv < 0) ? -gv : gv;
    den = (bv < VMIN) ? VMIN : bv;                 // R8
    q = (longint'(mag) * ONE) / den;
    if (q > ONE) q = ONE;                          // R2 saturation
    ff = pos ? ONE - int'(q) : int'(q);            // R2 / R3
    d = ff + corr;                                  // R4
    if (d < 0) d = 0;
    if (d > ONE) d = ONE;
    return (d * P) / ONE;                          // R5
  endfunction

  task automatic pulse_stb();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic run_case(input string tag, input int gv, input int bv, input int corr,
                          input bit pp, input bit pn, input bit kl);
    exp_t e;
    int thr;
    @(negedge clk);
    grid_v = W'(gv); bus_v = W'(bv); pi_duty = DCW'(corr);
    pol_pos = pp; pol_neg = pn; force_off = kl;
    pulse_stb();
    repeat (3 * P) @(negedge clk);
    e.tag = tag;
    if (!(pp ^ pn) || kl) begin
      e.main_n = 0; e.comp_n = 0;
    end else begin
      thr = exp_thr(gv, bv, corr, pp);
      e.main_n = (thr > DT) ? thr - DT : 0;
      if (thr == P) e.main_n = P;
      e.comp_n = (P - thr > DT) ? P - thr - DT : 0;
      if (thr == 0) e.comp_n = P;
    end
    sb_q.push_back(e);
    req_cnt++;
    wait (ack_cnt == req_cnt);
  endtask

  // monitor: measure one carrier period of each gate and compare
  initial begin
    exp_t e;
    int cm, cc;
    forever begin
      @(negedge clk);
      if (req_cnt != ack_cnt) begin
        cm = 0; cc = 0;
        for (int i = 0; i < P; i++) begin
          cm += int'(gate_main); cc += int'(gate_comp);
          @(negedge clk);
        end
        e = sb_q.pop_front();
        check(cm == e.main_n, e.tag, "gate_main high cycles", cm, e.main_n);
        check(cc == e.comp_n, e.tag, "gate_comp high cycles", cc, e.comp_n);
        ack_cnt++;
      end
    end
  end

  // continuous R6 observation
  always @(negedge clk) begin
    if (!rst) begin
      if (gate_comp && gate_main) overlap_err++;
      if ((gate_comp && !prev_c) || (gate_main && !prev_m))
        if (off_run < DT) gap_err++;
      off_run = (gate_comp || gate_main) ? 0 : off_run + 1;
    end
    prev_c = gate_comp; prev_m = gate_main;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rises;
    logic pm;
    repeat (5) @(negedge clk);
    check(gate_main == 1'b0, "R1", "gate_main in reset", int'(gate_main), 0);
    check(gate_comp == 1'b0, "R1", "gate_comp in reset", int'(gate_comp), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(gate_main == 1'b0, "R1", "gate_main after reset", int'(gate_main), 0);
    check(gate_comp == 1'b0, "R1", "gate_comp after reset", int'(gate_comp), 0);

    run_case("R2 positive ratio",       1000, 4000,    0, 1, 0, 0);
    run_case("R3 negative ratio",      -1000, 4000,    0, 0, 1, 0);
    run_case("R4 positive correction",  1000, 4000,  400, 1, 0, 0);
    run_case("R4 negative correction", -1000, 4000, -600, 0, 1, 0);
    run_case("R4 R5 clamp at one",         0, 4000,  100, 1, 0, 0);
    run_case("R4 R5 clamp at zero",        0, 4000, -200, 0, 1, 0);
    run_case("R2 ratio above one",      5000, 4000,    0, 1, 0, 0);
    run_case("R3 ratio above one",     -5000, 4000,    0, 0, 1, 0);
    run_case("R8 zero bus",               32,    0,    0, 1, 0, 0);
    run_case("R8 negative bus",           32, -500,    0, 1, 0, 0);
    run_case("R8 bus above floor",        32,  128,    0, 1, 0, 0);
    run_case("R5 threshold below deadtime", -80, 4000, 0, 0, 1, 0);
    run_case("R7 no flag",              1000, 4000,    0, 0, 0, 0);
    run_case("R7 both flags",           1000, 4000,    0, 1, 1, 0);
    run_case("R7 force off",            1000, 4000,    0, 1, 0, 1);
    run_case("R2 re-enabled",           1000, 4000,    0, 1, 0, 0);

    // R9: samples arrive off the carrier grid with alternating corrections
    rises = 0; pm = gate_main;
    grid_v = W'(1000); bus_v = W'(4000); pol_pos = 1'b1; pol_neg = 1'b0; force_off = 1'b0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (i >= 300 && gate_main && !pm) rises++;
      pm = gate_main;
      if (i % 137 == 0) begin
        stb = 1'b1;
        pi_duty = ((i / 137) % 2 == 0) ? DCW'(0) : DCW'(-2000);
      end else begin
        stb = 1'b0;
      end
    end
    check(rises == 10, "R9", "gate_main rises in ten periods", rises, 10);

    check(overlap_err == 0, "R6", "cycles with both gates high", overlap_err, 0);
    check(gap_err == 0, "R6", "turn-ons with short dead-time", gap_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule